// File: doc/BRIEF.md
# Stepper Step Translator with Decay Selection

This block turns a pulse-per-step command into the current set-points of a two-phase bipolar stepper. It walks an eight-position electrical cycle. Each position sets a current magnitude and a sign for each winding. A rising edge on the step input moves the cycle one increment, either forward or backward. The increment is one position in half-step resolution. In full-step resolution it moves between the four positions where both windings carry equal current.

For each winding the block also chooses a decay flag for the downstream chopper. If that winding's magnitude falls at the step, the flag selects Mixed decay. If the magnitude rises or stays the same, it selects Slow decay. An output-enable flag tells the bridges whether they may drive.

The analogue converter, the bridges and the chopping loop sit outside this block. It drives only digital codes to them.

Top module: `stepx_top`

## Requirements
- R1: The position index `pos_idx` runs from 0 to 7. Each index maps to a level for each winding, coded as a magnitude (0 = zero, 1 = 70.71 %, 2 = 100 %) and a sign bit (1 = negative, 0 for zero or positive). For phase 1, indices 0..7 give +2, +1, 0, -1, -2, -1, 0, +1. For phase 2, indices 0..7 give 0, +1, +2, +1, 0, -1, -2, -1.
- R2: While `rst_n` is low at a clock edge, the block does three things at that edge. It loads the home index 1. It sets both decay flags to Mixed (`phX_mixed` = 1). It clears `drive_on`.
- R3: In full-step resolution (`half_in` = 0), from an odd index (a full-step position), a step moves two indices. In half-step resolution (`half_in` = 1), a step always moves one index.
- R4: Only a low-to-high transition on `step_in` moves the index. Changing `dir_in` or `half_in` while `step_in` holds still has no effect. Holding `step_in` high moves the index only once.
- R5: With `dir_in` = 1 the index increases. With `dir_in` = 0 it decreases. It wraps between 7 and 0.
- R6: Step edges that occur while `rst_n` is low are ignored. The index stays at home after reset is released.
- R7: At each step, a winding whose new magnitude is lower than its previous magnitude gets Mixed decay (flag 1). Otherwise it gets Slow decay (flag 0). The flag holds its value until the next step.
- R8: `drive_on` is 1 one edge after any edge where `rst_n` is high and `drv_disable` is low. Otherwise it is 0. `drv_disable` has no effect on stepping.
- R9: In full-step resolution, a step from an even index moves one index, onto the adjacent full-step position in the chosen direction.
- R10: `step_in` passes through a two-flop synchroniser. The index and levels change at the third rising clock edge after `step_in` goes high, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also the translator home command |
| step_in | input | 1 | Step command, asynchronous, acts on rising edge |
| dir_in | input | 1 | Direction: 1 increasing index, 0 decreasing |
| half_in | input | 1 | Resolution: 1 half step, 0 full step |
| drv_disable | input | 1 | 1 forces the output-enable flag off |
| ph1_mag | output | 2 | Phase 1 magnitude code |
| ph1_neg | output | 1 | Phase 1 sign, 1 = negative |
| ph1_mixed | output | 1 | Phase 1 decay, 1 = Mixed, 0 = Slow |
| ph2_mag | output | 2 | Phase 2 magnitude code |
| ph2_neg | output | 1 | Phase 2 sign, 1 = negative |
| ph2_mixed | output | 1 | Phase 2 decay, 1 = Mixed, 0 = Slow |
| drive_on | output | 1 | Bridges may drive |
| pos_idx | output | 3 | Current cycle position index |

## Verification
A corrupted position register shows up at once on `pos_idx` and on both windings' level codes. It also stays visible, because every later step starts from the wrong place. A wrong decay decision shows up on a flag at the edge where the step lands. That flag then holds until the next step, so it is checked one sample after each step. A wrong synchroniser depth moves the update by one edge, and the check of the exact landing edge catches that shift.

// File: rtl/stepx_pkg.sv
// Shared types and the electrical-cycle level function for the step translator.
// Assumes an eight-position cycle, with phase 2 lagging phase 1 by two positions.
package stepx_pkg;
    localparam int POS_N = 8;
    localparam int POS_W = $clog2(POS_N);
    localparam logic [POS_W-1:0] HOME_POS = 3'd1;

    typedef logic [1:0] mag_t;

    typedef struct packed {
        logic neg;
        mag_t mag;
    } lvl_t;

    // Cosine-shaped level at index k: magnitude 2 at k%4==0, 0 at k%4==2, else 1.
    function automatic lvl_t cycle_level(input logic [POS_W-1:0] k);
        lvl_t r;
        case (k[1:0])
            2'd0:    r.mag = 2'd2;
            2'd2:    r.mag = 2'd0;
            default: r.mag = 2'd1;
        endcase
        r.neg = (k == 3'd3) || (k == 3'd4) || (k == 3'd5);
        return r;
    endfunction
endpackage

// File: rtl/stepx_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous control bits.
// Assumes the bits are held stable for several clocks around a change.
module stepx_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture stage
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                // Following resolution stage
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/stepx_seq.sv
// Position sequencer: moves the cycle index on each step request.
// Assumes adv is a one-cycle pulse; dir/half are valid in that cycle.
module stepx_seq
    import stepx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             dir,
    input  logic             half,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] pos_next
);
    logic [POS_W-1:0] delta;

    // Step size: two only in full-step mode from a full-step (odd) position
    always_comb begin
        delta = (!half && pos[0]) ? POS_W'(2) : POS_W'(1);
        pos_next = dir ? (pos + delta) : (pos - delta);
    end

    // Index register, home on reset
    always_ff @(posedge clk) begin
        if (!rst_n)   pos <= HOME_POS;
        else if (adv) pos <= pos_next;
    end

    assert_hold_no_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(pos));
    assert_moves_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> pos != $past(pos));
    assert_full_stays_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !half && pos[0]) |=> pos[0]);
    assert_full_realigns_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !half && !pos[0]) |=> pos[0]);
    assert_wrap_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && dir && half && pos == 3'd7) |=> pos == 3'd0);
endmodule

// File: rtl/stepx_phase.sv
// One winding: level decode and automatic decay selection at each step.
// Assumes pos/pos_next come from the sequencer; LAG shifts the cycle per phase.
module stepx_phase
    import stepx_pkg::*;
#(
    parameter int LAG = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] pos_next,
    output lvl_t             lvl,
    output logic             mixed
);
    localparam logic [POS_W-1:0] LAG_V = POS_W'(LAG);
    lvl_t lvl_new;

    // Present and upcoming level for this winding
    always_comb begin
        lvl     = cycle_level(pos - LAG_V);
        lvl_new = cycle_level(pos_next - LAG_V);
    end

    // Decay flag: Mixed when magnitude falls, Slow otherwise; Mixed after reset
    always_ff @(posedge clk) begin
        if (!rst_n)   mixed <= 1'b1;
        else if (adv) mixed <= (lvl_new.mag < lvl.mag);
    end

    assert_flag_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(mixed));
    assert_mag_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lvl.mag != 2'd3);
endmodule

// File: rtl/stepx_top.sv
// Step translator top: synchronises step/dir/resolution, finds the step edge,
// sequences the cycle and drives per-phase levels, decay flags and enable.
// Assumes dir_in/half_in are stable around step_in rising.
module stepx_top
    import stepx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_in,
    input  logic       dir_in,
    input  logic       half_in,
    input  logic       drv_disable,
    output logic [1:0] ph1_mag,
    output logic       ph1_neg,
    output logic       ph1_mixed,
    output logic [1:0] ph2_mag,
    output logic       ph2_neg,
    output logic       ph2_mixed,
    output logic       drive_on,
    output logic [2:0] pos_idx
);
    localparam int NPH = 2;

    logic [2:0]       ctl_s;
    logic             step_d;
    logic             adv;
    logic [POS_W-1:0] pos, pos_next;
    lvl_t             lvl   [NPH];
    logic             mixed [NPH];

    stepx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({half_in, dir_in, step_in}),
        .q_sync  (ctl_s)
    );

    // Previous synchronised step level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) step_d <= 1'b0;
        else        step_d <= ctl_s[0];
    end

    assign adv = ctl_s[0] && !step_d;

    stepx_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .dir      (ctl_s[1]),
        .half     (ctl_s[2]),
        .pos      (pos),
        .pos_next (pos_next)
    );

    generate
        for (genvar p = 0; p < NPH; p++) begin : g_phase
            stepx_phase #(.LAG(2 * p)) u_phase (
                .clk      (clk),
                .rst_n    (rst_n),
                .adv      (adv),
                .pos      (pos),
                .pos_next (pos_next),
                .lvl      (lvl[p]),
                .mixed    (mixed[p])
            );
        end
    endgenerate

    // Output-enable flag, off in reset or when disabled
    always_ff @(posedge clk) begin
        if (!rst_n) drive_on <= 1'b0;
        else        drive_on <= !drv_disable;
    end

    assign ph1_mag   = lvl[0].mag;
    assign ph1_neg   = lvl[0].neg;
    assign ph1_mixed = mixed[0];
    assign ph2_mag   = lvl[1].mag;
    assign ph2_neg   = lvl[1].neg;
    assign ph2_mixed = mixed[1];
    assign pos_idx   = pos;

    assert_home_on_reset_R2: assert property (@(posedge clk)
        !rst_n |=> (pos_idx == 3'd1 && ph1_mixed && ph2_mixed && !drive_on));
    assert_decay_ph1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(adv) |-> (ph1_mixed == (ph1_mag < $past(ph1_mag))));
    assert_decay_ph2_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(adv) |-> (ph2_mixed == (ph2_mag < $past(ph2_mag))));
    assert_disable_gates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drv_disable |=> !drive_on);
    assert_zero_unsigned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((ph1_mag != 2'd0 || !ph1_neg) && (ph2_mag != 2'd0 || !ph2_neg)));
endmodule

// File: tb/tb_stepx_top.sv
`timescale 1ns/1ps
module tb_stepx_top;
    logic       clk = 1'b0;
    logic       rst_n, step_in, dir_in, half_in, drv_disable;
    logic [1:0] ph1_mag, ph2_mag;
    logic       ph1_neg, ph2_neg, ph1_mixed, ph2_mixed, drive_on;
    logic [2:0] pos_idx;

    int n_checks = 0;
    int n_errors = 0;
    logic [2:0] m_pos;
    logic [1:0] m_mixed;
    bit done = 0;

    always #5 clk = ~clk;

    stepx_top dut (
        .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in),
        .half_in(half_in), .drv_disable(drv_disable),
        .ph1_mag(ph1_mag), .ph1_neg(ph1_neg), .ph1_mixed(ph1_mixed),
        .ph2_mag(ph2_mag), .ph2_neg(ph2_neg), .ph2_mixed(ph2_mixed),
        .drive_on(drive_on), .pos_idx(pos_idx)
    );

    // Expected {neg, mag} of phase 1 at index p (R1 table)
    function automatic logic [2:0] ref_p1(input logic [2:0] p);
        case (p)
            3'd0: return 3'b0_10;  3'd1: return 3'b0_01;
            3'd2: return 3'b0_00;  3'd3: return 3'b1_01;
            3'd4: return 3'b1_10;  3'd5: return 3'b1_01;
            3'd6: return 3'b0_00;  default: return 3'b0_01;
        endcase
    endfunction

    // Expected {neg, mag} of phase 2 at index p (R1 table)
    function automatic logic [2:0] ref_p2(input logic [2:0] p);
        case (p)
            3'd0: return 3'b0_00;  3'd1: return 3'b0_01;
            3'd2: return 3'b0_10;  3'd3: return 3'b0_01;
            3'd4: return 3'b0_00;  3'd5: return 3'b1_01;
            3'd6: return 3'b1_10;  default: return 3'b1_01;
        endcase
    endfunction

    function automatic logic [2:0] ref_next(input logic [2:0] p, input logic d, input logic h);
        logic [2:0] dl;
        dl = (!h && p[0]) ? 3'd2 : 3'd1;
        return d ? p + dl : p - dl;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare all port outputs with the model
    task automatic check_all(input string req);
        check(req, {pos_idx, ph1_neg, ph1_mag, ph2_neg, ph2_mag, ph1_mixed, ph2_mixed, drive_on},
              {m_pos, ref_p1(m_pos), ref_p2(m_pos), m_mixed, !drv_disable});
    endtask

    task automatic model_step(input logic d, input logic h);
        logic [2:0] np;
        np = ref_next(m_pos, d, h);
        m_mixed[1] = ref_p1(np)[1:0] < ref_p1(m_pos)[1:0];
        m_mixed[0] = ref_p2(np)[1:0] < ref_p2(m_pos)[1:0];
        m_pos = np;
    endtask

    task automatic do_step(input logic d, input logic h, input string req);
        dir_in = d; half_in = h;
        repeat (3) @(negedge clk);
        step_in = 1'b1;
        model_step(d, h);
        repeat (3) @(negedge clk);
        check_all(req);
        step_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step_in = 1'b0;
        repeat (4) @(negedge clk);
        m_pos = 3'd1; m_mixed = 2'b11;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [2:0] p0;
        void'($urandom(32'd4242));
        rst_n = 1'b0; step_in = 1'b0; dir_in = 1'b1; half_in = 1'b1; drv_disable = 1'b0;
        m_pos = 3'd1; m_mixed = 2'b11;
        repeat (3) @(negedge clk);
        // R2: reset state, drive off
        check("R2", {pos_idx, ph1_mixed, ph2_mixed, drive_on}, {3'd1, 2'b11, 1'b0});
        // R6: step pulses under reset are ignored
        step_in = 1'b1; repeat (4) @(negedge clk);
        step_in = 1'b0; repeat (4) @(negedge clk);
        rst_n = 1'b1; repeat (5) @(negedge clk);
        check("R6", {13'd0, pos_idx}, {13'd0, 3'd1});
        check_all("R2");
        // R10: landing edge after two-flop synchroniser
        step_in = 1'b1; model_step(1'b1, 1'b1);
        repeat (2) @(negedge clk);
        check("R10", {13'd0, pos_idx}, {13'd0, 3'd1});
        @(negedge clk);
        check("R10", {13'd0, pos_idx}, {13'd0, m_pos});
        // R4: held step high moves once; dir/half toggles without edge
        dir_in = 1'b0; half_in = 1'b0; repeat (6) @(negedge clk);
        dir_in = 1'b1; half_in = 1'b1; repeat (6) @(negedge clk);
        check_all("R4");
        step_in = 1'b0; repeat (4) @(negedge clk);
        // R1 R5 R7: half-step walk both ways with wrap
        for (int i = 0; i < 9; i++) do_step(1'b1, 1'b1, "R1_R5_R7");
        for (int i = 0; i < 10; i++) do_step(1'b0, 1'b1, "R1_R5_R7");
        // R3: full-step walk from a full position, both directions
        if (!m_pos[0]) do_step(1'b1, 1'b1, "R5");
        for (int i = 0; i < 5; i++) begin
            p0 = m_pos; do_step(1'b1, 1'b0, "R3");
            check("R3", {13'd0, pos_idx}, {13'd0, p0 + 3'd2});
        end
        for (int i = 0; i < 5; i++) do_step(1'b0, 1'b0, "R3_R7");
        // R9: full-step from a half position moves one
        do_step(1'b1, 1'b1, "R5");
        p0 = m_pos; do_step(1'b0, 1'b0, "R9");
        check("R9", {13'd0, pos_idx}, {13'd0, p0 - 3'd1});
        do_step(1'b1, 1'b1, "R5");
        p0 = m_pos; do_step(1'b1, 1'b0, "R9");
        check("R9", {13'd0, pos_idx}, {13'd0, p0 + 3'd1});
        // R8: disable gates only the enable flag
        drv_disable = 1'b1; @(negedge clk);
        do_step(1'b1, 1'b1, "R8");
        check("R8", {15'd0, drive_on}, 16'd0);
        drv_disable = 1'b0; @(negedge clk);
        check("R8", {15'd0, drive_on}, 16'd1);
        // Random mix
        for (int i = 0; i < 150; i++) begin
            drv_disable = ($urandom % 5) == 0;
            do_step(1'($urandom), 1'($urandom), "R1_R3_R5_R7_R9");
        end
        drv_disable = 1'b0;
        // R2: reset mid-run returns home with Mixed flags
        rst_n = 1'b0; repeat (2) @(negedge clk);
        check("R2", {pos_idx, ph1_mixed, ph2_mixed, drive_on}, {3'd1, 2'b11, 1'b0});
        do_reset();
        check_all("R2");
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule